// File: doc/BRIEF.md
# Ternary Match Classifier with Action Lookup

This block classifies a search key against a table of ternary rules. Each rule holds a value word, a care mask of the key's width and a valid flag. All rules are compared with the key at the same time. When several rules match, the one at the lowest table position wins, and its position selects a word from a separate action table. That word is the classification result. When no rule matches, the block returns a miss and a default action fixed by a parameter.

Rules and action words are loaded through two write ports, one for each table. A search is presented for one cycle together with its key. The result comes out two cycles later: the first stage compares and resolves priority, the second reads the action word. The pipeline accepts a new search every cycle.

Top module: `tcam_classifier`

## Requirements
- R1: A key bit whose rule mask bit is 0 is a don't-care. The rule can match whatever the key bit or the stored value bit is.
- R2: A key bit whose rule mask bit is 1 matches only if it equals the stored value bit.
- R3: A rule matches only when all KEY_W bit positions match. A single differing cared-for bit gives no match.
- R4: A rule whose valid flag is 0 never matches. Every rule is invalid after reset, so any search after reset misses.
- R5: When several rules match, the one with the lowest index wins. This holds whether the winner is an exact rule or a wildcard rule.
- R6: On a hit, res_action_o is the action-table word at the winning index, as written by the last action write to that index. res_idx_o is the winning index.
- R7: On a miss, res_hit_o is 0, res_idx_o is 0 and res_action_o equals the parameter DEFAULT_ACT (default 8'hFF).
- R8: A search sampled at a rising edge produces res_valid_o = 1 with its result after the second following rising edge. Searches on consecutive cycles give results on consecutive cycles, in order. res_valid_o is 0 in cycles that carry no result.
- R9: A rule write replaces the value, mask and valid flag of that index for all searches sampled after the write edge. Writing valid = 0 removes the rule.
- R10: During and after reset res_valid_o and res_hit_o are 0, and all action words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rule_we_i | input | 1 | Rule write strobe |
| rule_idx_i | input | IDX_W | Rule index to write |
| rule_value_i | input | KEY_W | Stored value word |
| rule_mask_i | input | KEY_W | Care mask (1 = compare, 0 = don't care) |
| rule_valid_i | input | 1 | Valid flag written with the rule |
| act_we_i | input | 1 | Action write strobe |
| act_idx_i | input | IDX_W | Action index to write |
| act_data_i | input | ACT_W | Action word |
| srch_valid_i | input | 1 | Search request |
| srch_key_i | input | KEY_W | Search key |
| res_valid_o | output | 1 | Result strobe |
| res_hit_o | output | 1 | A rule matched |
| res_idx_o | output | IDX_W | Winning rule index (0 on miss) |
| res_action_o | output | ACT_W | Action word or DEFAULT_ACT |

## Verification
Every search result is due after the second rising edge that follows the edge sampling the request. The bench drives each request on a falling edge, counts two rising edges and reads the result on the falling edge after that. In the back-to-back scenario it reads one result on each following falling edge and then confirms that the strobe drops. Table writes finish a full cycle before any search that depends on them, so every expected result is fixed by the table state the requirements describe.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  // ternary compare of one rule: mask bit 1 = compare, 0 = don't care
  function automatic logic tern_match(input logic [63:0] key,
                                      input logic [63:0] value,
                                      input logic [63:0] mask);
    return ((key ^ value) & mask) == 64'd0;
  endfunction

endpackage

// File: rtl/tcam_rule_array.sv
module tcam_rule_array import tcam_pkg::*; #(
  parameter int KEY_W   = 16,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [KEY_W-1:0]   value_i,
  input  logic [KEY_W-1:0]   mask_i,
  input  logic               valid_i,
  input  logic [KEY_W-1:0]   key_i,
  output logic [ENTRIES-1:0] match_o
);

  logic [KEY_W-1:0]   value_q [ENTRIES];
  logic [KEY_W-1:0]   mask_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rule
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        value_q[g] <= '0;
        mask_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (we_i && (int'(idx_i) == g)) begin
        value_q[g] <= value_i;
        mask_q[g]  <= mask_i;
        valid_q[g] <= valid_i;
      end
    end

    assign match_o[g] = valid_q[g] &&
                        tern_match(64'(key_i), 64'(value_q[g]), 64'(mask_q[g]));
  end

  // a rule written invalid cannot match on the next cycle
  p_cleared_nomatch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !valid_i && (int'(idx_i) < ENTRIES)) |=> !match_o[$past(idx_i)]);

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] match_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  // scan downward so the lowest matching index is the last assignment
  always_comb begin
    hit_o = |match_i;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tcam_action_mem.sv
module tcam_action_mem #(
  parameter int ENTRIES = 8,
  parameter int ACT_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ACT_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ACT_W-1:0] rd_data_o
);

  logic [ACT_W-1:0] mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (we_i && (int'(wr_idx_i) == g))   mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (int'(rd_idx_i) == i) rd_data_o = mem_q[i];
    end
  end

endmodule

// File: rtl/tcam_classifier.sv
module tcam_classifier #(
  parameter int KEY_W                   = 16,
  parameter int ENTRIES                 = 8,
  parameter int ACT_W                   = 8,
  parameter logic [ACT_W-1:0] DEFAULT_ACT = 8'hFF,
  localparam int IDX_W                  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rule_we_i,
  input  logic [IDX_W-1:0] rule_idx_i,
  input  logic [KEY_W-1:0] rule_value_i,
  input  logic [KEY_W-1:0] rule_mask_i,
  input  logic             rule_valid_i,
  input  logic             act_we_i,
  input  logic [IDX_W-1:0] act_idx_i,
  input  logic [ACT_W-1:0] act_data_i,
  input  logic             srch_valid_i,
  input  logic [KEY_W-1:0] srch_key_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic [IDX_W-1:0] res_idx_o,
  output logic [ACT_W-1:0] res_action_o
);

  logic [ENTRIES-1:0] match_vec;
  logic               enc_hit;
  logic [IDX_W-1:0]   enc_idx;
  logic [ACT_W-1:0]   act_rd;

  // stage 1: compare + priority
  logic               s1_valid_q, s1_hit_q;
  logic [IDX_W-1:0]   s1_idx_q;

  tcam_rule_array #(.KEY_W(KEY_W), .ENTRIES(ENTRIES)) u_rules (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rule_we_i),
    .idx_i   (rule_idx_i),
    .value_i (rule_value_i),
    .mask_i  (rule_mask_i),
    .valid_i (rule_valid_i),
    .key_i   (srch_key_i),
    .match_o (match_vec)
  );

  tcam_prio_enc #(.ENTRIES(ENTRIES)) u_enc (
    .match_i (match_vec),
    .hit_o   (enc_hit),
    .idx_o   (enc_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_hit_q   <= 1'b0;
      s1_idx_q   <= '0;
    end else begin
      s1_valid_q <= srch_valid_i;
      s1_hit_q   <= srch_valid_i && enc_hit;
      s1_idx_q   <= enc_hit ? enc_idx : '0;
    end
  end

  // stage 2: action read
  tcam_action_mem #(.ENTRIES(ENTRIES), .ACT_W(ACT_W)) u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (act_we_i),
    .wr_idx_i  (act_idx_i),
    .wr_data_i (act_data_i),
    .rd_idx_i  (s1_idx_q),
    .rd_data_o (act_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_idx_o    <= '0;
      res_action_o <= '0;
    end else begin
      res_valid_o  <= s1_valid_q;
      res_hit_o    <= s1_valid_q && s1_hit_q;
      res_idx_o    <= (s1_valid_q && s1_hit_q) ? s1_idx_q : '0;
      res_action_o <= (s1_valid_q && s1_hit_q) ? act_rd : DEFAULT_ACT;
    end
  end

  // priority encoder picks a matching rule with nothing below it
  p_winner_matches_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_hit |-> match_vec[enc_idx]);
  p_winner_lowest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_hit |-> ((match_vec & ((ENTRIES'(1) << enc_idx) - ENTRIES'(1))) == '0));
  p_nohit_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_hit |-> (match_vec == '0));
  p_miss_default_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o) |-> (res_action_o == DEFAULT_ACT && res_idx_o == '0));
  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_valid_i |=> ##1 res_valid_o);
  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_valid_i |=> ##1 !res_valid_o);
  p_hit_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> res_valid_o);

endmodule

// File: tb/tcam_classifier_test.sv
module tcam_classifier_test;

  localparam int KEY_W = 16;
  localparam int ENTRIES = 8;
  localparam int ACT_W = 8;
  localparam int IDX_W = 3;
  localparam logic [7:0] DFLT = 8'hFF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rule_we = 1'b0;
  logic [IDX_W-1:0] rule_idx = '0;
  logic [KEY_W-1:0] rule_value = '0;
  logic [KEY_W-1:0] rule_mask = '0;
  logic             rule_valid = 1'b0;
  logic             act_we = 1'b0;
  logic [IDX_W-1:0] act_idx = '0;
  logic [ACT_W-1:0] act_data = '0;
  logic             srch_valid = 1'b0;
  logic [KEY_W-1:0] srch_key = '0;
  logic             res_valid, res_hit;
  logic [IDX_W-1:0] res_idx;
  logic [ACT_W-1:0] res_action;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tcam_classifier #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .ACT_W(ACT_W), .DEFAULT_ACT(DFLT)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rule_we_i(rule_we), .rule_idx_i(rule_idx), .rule_value_i(rule_value),
    .rule_mask_i(rule_mask), .rule_valid_i(rule_valid),
    .act_we_i(act_we), .act_idx_i(act_idx), .act_data_i(act_data),
    .srch_valid_i(srch_valid), .srch_key_i(srch_key),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_idx_o(res_idx),
    .res_action_o(res_action)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input bit e_hit, input int e_idx, input logic [7:0] e_act);
    chk(res_valid == 1'b1, {req, " valid"}, 32'(res_valid), 32'd1);
    chk(res_hit == e_hit, {req, " hit"}, 32'(res_hit), 32'(e_hit));
    chk(int'(res_idx) == e_idx, {req, " idx"}, 32'(res_idx), 32'(e_idx));
    chk(res_action == e_act, {req, " action"}, 32'(res_action), 32'(e_act));
  endtask

  task automatic wr_rule(input int idx, input logic [15:0] v, input logic [15:0] m, input bit vld);
    @(negedge clk);
    rule_we = 1'b1; rule_idx = IDX_W'(idx); rule_value = v; rule_mask = m; rule_valid = vld;
    @(negedge clk);
    rule_we = 1'b0;
  endtask

  task automatic wr_act(input int idx, input logic [7:0] d);
    @(negedge clk);
    act_we = 1'b1; act_idx = IDX_W'(idx); act_data = d;
    @(negedge clk);
    act_we = 1'b0;
  endtask

  // drive on a falling edge, result is read two rising edges later
  task automatic search(input logic [15:0] key, input string req,
                        input bit e_hit, input int e_idx, input logic [7:0] e_act);
    @(negedge clk);
    srch_valid = 1'b1; srch_key = key;
    @(negedge clk);
    srch_valid = 1'b0;
    @(negedge clk);
    chk_res(req, e_hit, e_idx, e_act);
  endtask

  task automatic t_reset;
    chk(res_valid == 1'b0, "R10 valid in reset", 32'(res_valid), 0);
    chk(res_hit == 1'b0, "R10 hit in reset", 32'(res_hit), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(res_valid == 1'b0, "R10 valid after reset", 32'(res_valid), 0);
  endtask

  task automatic t_empty;
    search(16'h1234, "R4 empty table miss", 1'b0, 0, DFLT);
    search(16'h0000, "R7 miss default", 1'b0, 0, DFLT);
  endtask

  task automatic t_load_actions;
    for (int i = 0; i < ENTRIES; i++) wr_act(i, 8'h10 + 8'(i));
  endtask

  task automatic t_exact;
    wr_rule(2, 16'hA5C3, 16'hFFFF, 1'b1);
    search(16'hA5C3, "R2 exact hit", 1'b1, 2, 8'h12);
    search(16'hA5C2, "R3 one bit off", 1'b0, 0, DFLT);
  endtask

  task automatic t_mask;
    wr_rule(5, 16'h1200, 16'hFF00, 1'b1);
    wr_rule(6, 16'h34FF, 16'hFF00, 1'b1);
    search(16'h12AB, "R1 low byte dont care", 1'b1, 5, 8'h15);
    search(16'h13AB, "R2 cared bit differs", 1'b0, 0, DFLT);
    search(16'h3400, "R1 stored value ignored", 1'b1, 6, 8'h16);
  endtask

  task automatic t_priority;
    wr_rule(1, 16'h12AB, 16'hFFFF, 1'b1);
    search(16'h12AB, "R5 exact over wildcard", 1'b1, 1, 8'h11);
    search(16'h12CD, "R5 only wildcard", 1'b1, 5, 8'h15);
    wr_rule(0, 16'h3400, 16'hFF00, 1'b1);
    search(16'h3477, "R5 low wildcard wins", 1'b1, 0, 8'h10);
  endtask

  task automatic t_invalidate;
    wr_rule(0, 16'h3400, 16'hFF00, 1'b0);
    search(16'h3477, "R4 invalidated rule", 1'b1, 6, 8'h16);
    wr_rule(1, 16'hFFFF, 16'hFFFF, 1'b1);
    search(16'h12AB, "R9 old value gone", 1'b1, 5, 8'h15);
    search(16'hFFFF, "R9 new value", 1'b1, 1, 8'h11);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); srch_valid = 1'b1; srch_key = 16'hA5C3;
    @(negedge clk); srch_key = 16'h0000;
    @(negedge clk); srch_key = 16'h12CD;
    chk_res("R8 first", 1'b1, 2, 8'h12);
    @(negedge clk); srch_valid = 1'b0;
    chk_res("R8 second", 1'b0, 0, DFLT);
    @(negedge clk);
    chk_res("R8 third", 1'b1, 5, 8'h15);
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 idle after burst", 32'(res_valid), 0);
  endtask

  task automatic t_action_update;
    wr_act(5, 8'h5A);
    search(16'h12CD, "R6 rewritten action", 1'b1, 5, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_empty();
    t_load_actions();
    t_exact();
    t_mask();
    t_priority();
    t_invalidate();
    t_back_to_back();
    t_action_update();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule